// File: doc/BRIEF.md
# SPI Two-Port Register Access Controller

This block lets a host reach a small register set over a four-wire serial link while the register logic runs on the system clock. The serial side is a 16-bit SPI slave (mode 0, most significant bit first) clocked only by the host's select and serial clock. It has no timing relationship to the system clock. A two-flop synchronizer brings the link's busy level (select asserted) into the system domain. When busy falls after a complete 16-bit frame, a small controller state machine decodes the captured word. It then either writes a register or loads the response word. The response word is shifted out during the following transaction.

There are two indirect access ports. Port 0 always reaches the control register. Port 1 reaches one of eight registers, and a select field inside the control register picks which one. The register set holds the control register (also reachable through port 1), a counter of port 1 reads, five scratch registers and a read-only identification constant.

The controller states are IDLE, DECODE, WRITE and READ. The transitions are:
- IDLE to DECODE, on busy falling while a new frame is waiting.
- DECODE to WRITE, for a valid write command.
- DECODE to READ, for a valid read command.
- DECODE to IDLE, for a command with a reserved bit set.
- WRITE to IDLE and READ to IDLE, unconditionally after one cycle.

Top module: `spi_dual_port_ctrl`

## Requirements
- R1: After reset the LED outputs are 0, MISO is 0 while select is high, and the first transfer returns 0x0000.
- R2: Frames are 16 bits, most significant bit first. MOSI is sampled on SCLK rising edges. MISO presents bit 15 once select is low and advances on each SCLK falling edge.
- R3: A read command's result is returned during the next transfer. Writes, ignored commands and incomplete frames leave the response word unchanged.
- R4: In the low nibble of the command, bit 0 selects the port and bit 1 = 1 means write. Bits 3:2 must be 0; otherwise the whole command is ignored.
- R5: A write stores command bits 15:4. Reading port 0 returns {4'h0, control[11:0]}.
- R6: Control bits 2:0 are the port 1 select and bits 6:3 drive the LED outputs. The LED outputs change only through a write to the control register.
- R7: The port 1 select maps as follows: 0 is the control register itself (reads and writes), 1 is the read counter, 2 to 6 are scratch registers read as {4'h0, data}, and 7 is the constant 0x0A17.
- R8: Writes through port 1 to selections 1 and 7 are ignored.
- R9: Every port 1 read increments the read counter by exactly 1. A read of selection 1 returns the value the counter had before that read. Port 0 reads do not count.
- R10: A frame with fewer than 16 SCLK rising edges causes no register write and no read.
- R11: The controller leaves IDLE only on a falling edge of the synchronized busy level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the controller and registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Host select, active low |
| spi_sclk | input | 1 | Host serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, 0 while not selected |
| led_out | output | 4 | LED drive from control bits 6:3 |

## Verification
The assertions check the following on every system clock cycle:
- the controller stays in IDLE while busy is high, and DECODE lasts exactly one cycle;
- the LED outputs and the response word change only out of WRITE and READ respectively;
- the read counter moves only out of READ, and only by one.

The bench's scenarios show the behaviours no single-cycle property can see. These are the one-transfer delay of read data, the register map behind each select value, ignored writes to read-only selections and ignored reserved commands, and the discarding of a truncated frame. The bench checks all of these at the serial pins against a reference model.

// File: rtl/spi_dp_pkg.sv
package spi_dp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WRITE,
        ST_READ
    } ctl_state_t;

    // Command nibble bit positions (R4)
    localparam int CMD_PORT_BIT = 0;
    localparam int CMD_WR_BIT   = 1;

endpackage

// File: rtl/spi_link.sv
module spi_link #(
    parameter int WORD_W = 16
) (
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [WORD_W-1:0] tx_word,
    output logic [WORD_W-1:0] rx_word,
    output logic              frame_tgl
);
    localparam int CNT_W = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0]  rx_cnt;
    logic [CNT_W-1:0]  tx_cnt;
    logic [WORD_W-1:0] rx_sh;
    logic [WORD_W-1:0] tx_view;

    // Rising edge: sample MOSI; counter cleared while deselected
    always_ff @(posedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            rx_cnt <= '0;
            rx_sh  <= '0;
        end else begin
            rx_sh <= {rx_sh[WORD_W-2:0], spi_mosi};
            if (rx_cnt != CNT_FULL) begin
                rx_cnt <= rx_cnt + 1'b1;
            end
        end
    end

    // Completed word and a toggle marking each complete frame
    always_ff @(posedge spi_sclk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word   <= '0;
            frame_tgl <= 1'b0;
        end else if (!spi_cs_n && rx_cnt == CNT_LAST) begin
            rx_word   <= {rx_sh[WORD_W-2:0], spi_mosi};
            frame_tgl <= ~frame_tgl;
        end
    end

    // Falling edge: advance the outgoing bit index
    always_ff @(negedge spi_sclk or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            tx_cnt <= '0;
        end else if (tx_cnt != CNT_FULL) begin
            tx_cnt <= tx_cnt + 1'b1;
        end
    end

    assign tx_view  = tx_word << tx_cnt;
    assign spi_miso = !spi_cs_n && tx_view[WORD_W-1];

endmodule

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/port_ctrl_fsm.sv
module port_ctrl_fsm
    import spi_dp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CMD_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    busy_s,
    input  logic                    frame_tgl_s,
    input  logic [WORD_W-1:0]       rx_word,
    input  logic [WORD_W-1:0]       rd_data,
    output ctl_state_t              state,
    output logic                    wr_en,
    output logic                    rd_en,
    output logic                    port_sel,
    output logic [WORD_W-CMD_W-1:0] wr_data,
    output logic [WORD_W-1:0]       tx_word
);
    ctl_state_t        state_q, state_d;
    logic [WORD_W-1:0] cmd_q;
    logic              busy_d;
    logic              seen_tgl;
    logic              new_frame;
    logic              cmd_ok;

    assign new_frame = busy_d && !busy_s && (frame_tgl_s != seen_tgl);
    assign cmd_ok    = (cmd_q[CMD_W-1:CMD_WR_BIT+1] == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (new_frame) state_d = ST_DECODE;
            ST_DECODE: begin
                if (!cmd_ok)                 state_d = ST_IDLE;
                else if (cmd_q[CMD_WR_BIT])  state_d = ST_WRITE;
                else                         state_d = ST_READ;
            end
            ST_WRITE:  state_d = ST_IDLE;
            ST_READ:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output / datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_d   <= 1'b0;
            seen_tgl <= 1'b0;
            cmd_q    <= '0;
            tx_word  <= '0;
        end else begin
            busy_d <= busy_s;
            if (state_q == ST_IDLE && new_frame) begin
                cmd_q    <= rx_word;
                seen_tgl <= frame_tgl_s;
            end
            if (state_q == ST_READ) begin
                tx_word <= rd_data;
            end
        end
    end

    assign state    = state_q;
    assign wr_en    = (state_q == ST_WRITE);
    assign rd_en    = (state_q == ST_READ);
    assign port_sel = cmd_q[CMD_PORT_BIT];
    assign wr_data  = cmd_q[WORD_W-1:CMD_W];

endmodule

// File: rtl/port_reg_file.sv
module port_reg_file #(
    parameter int          WORD_W  = 16,
    parameter int          DATA_W  = 12,
    parameter int          SEL_W   = 3,
    parameter int          LED_W   = 4,
    parameter logic [15:0] ID_WORD = 16'h0A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              port_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] rd_cnt,
    output logic [LED_W-1:0]  led_out
);
    localparam int N_REGS  = 1 << SEL_W;
    localparam int IDX_CNT = 1;
    localparam int IDX_ID  = N_REGS - 1;
    localparam int PAD_W   = WORD_W - DATA_W;

    logic [DATA_W-1:0] ctrl_q;
    logic [SEL_W-1:0]  sel;
    logic [WORD_W-1:0] view [N_REGS];
    logic              ctrl_wr;

    assign sel     = ctrl_q[SEL_W-1:0];
    assign led_out = ctrl_q[SEL_W +: LED_W];
    assign ctrl_wr = wr_en && (!port_sel || sel == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_wr) ctrl_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   rd_cnt <= '0;
        else if (rd_en && port_sel)   rd_cnt <= rd_cnt + 1'b1;
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_slot
        if (g == 0) begin : g_ctrl
            assign view[g] = {{PAD_W{1'b0}}, ctrl_q};
        end else if (g == IDX_CNT) begin : g_cnt
            assign view[g] = rd_cnt;
        end else if (g == IDX_ID) begin : g_id
            assign view[g] = WORD_W'(ID_WORD);
        end else begin : g_scratch
            logic [DATA_W-1:0] data_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_q <= '0;
                end else if (wr_en && port_sel && sel == SEL_W'(g)) begin
                    data_q <= wr_data;
                end
            end
            assign view[g] = {{PAD_W{1'b0}}, data_q};
        end
    end

    assign rd_data = port_sel ? view[sel] : view[0];

endmodule

// File: rtl/spi_dual_port_ctrl.sv
module spi_dual_port_ctrl
    import spi_dp_pkg::*;
#(
    parameter int          WORD_W  = 16,
    parameter int          CMD_W   = 4,
    parameter int          SEL_W   = 3,
    parameter int          LED_W   = 4,
    parameter logic [15:0] ID_WORD = 16'h0A17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_cs_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic [LED_W-1:0] led_out
);
    localparam int DATA_W = WORD_W - CMD_W;

    logic [WORD_W-1:0] rx_word;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] rd_data;
    logic [WORD_W-1:0] rd_cnt;
    logic [DATA_W-1:0] wr_data;
    logic              frame_tgl;
    logic              busy_s;
    logic              frame_tgl_s;
    logic              wr_en;
    logic              rd_en;
    logic              port_sel;
    ctl_state_t        fsm_state;

    spi_link #(.WORD_W(WORD_W)) u_link (
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_miso (spi_miso),
        .tx_word  (tx_word),
        .rx_word  (rx_word),
        .frame_tgl(frame_tgl)
    );

    bit_sync #(.W(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({~spi_cs_n, frame_tgl}),
        .q    ({busy_s, frame_tgl_s})
    );

    port_ctrl_fsm #(.WORD_W(WORD_W), .CMD_W(CMD_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_s     (busy_s),
        .frame_tgl_s(frame_tgl_s),
        .rx_word    (rx_word),
        .rd_data    (rd_data),
        .state      (fsm_state),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .port_sel   (port_sel),
        .wr_data    (wr_data),
        .tx_word    (tx_word)
    );

    port_reg_file #(
        .WORD_W (WORD_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .LED_W  (LED_W),
        .ID_WORD(ID_WORD)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .port_sel(port_sel),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .rd_cnt  (rd_cnt),
        .led_out (led_out)
    );

endmodule

// File: rtl/spi_dual_port_ctrl_chk.sv
module spi_dual_port_ctrl_chk
    import spi_dp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int LED_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input ctl_state_t        state,
    input logic              busy_s,
    input logic [LED_W-1:0]  led_out,
    input logic [WORD_W-1:0] tx_word,
    input logic [WORD_W-1:0] rd_cnt
);
    p_idle_waits_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && busy_s) |=> (state == ST_IDLE));

    p_decode_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE) |=> (state != ST_DECODE));

    p_led_write_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WRITE) |=> $stable(led_out));

    p_tx_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READ) |=> $stable(tx_word));

    p_cnt_read_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_READ) |=> $stable(rd_cnt));

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_cnt) |-> (rd_cnt == $past(rd_cnt) + 1'b1));

endmodule

bind spi_dual_port_ctrl spi_dual_port_ctrl_chk #(
    .WORD_W(WORD_W),
    .LED_W (LED_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (fsm_state),
    .busy_s (busy_s),
    .led_out(led_out),
    .tx_word(tx_word),
    .rd_cnt (rd_cnt)
);

// File: tb/spi_dual_port_ctrl_tb.sv
module spi_dual_port_ctrl_tb;

    localparam logic [15:0] ID_WORD = 16'h0A17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic [3:0] led_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model state
    logic [11:0] m_ctrl = '0;
    logic [11:0] m_scr [8];
    logic [15:0] m_cnt = '0;
    logic [15:0] m_tx = '0;

    // Scoreboard queues
    logic [15:0] exp_q [$];
    logic [15:0] act_q [$];
    string       tag_q [$];
    event        xfer_ev;

    always #2 clk = ~clk;

    spi_dual_port_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi),
        .spi_miso(spi_miso),
        .led_out (led_out)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_view(input logic [2:0] s);
        case (s)
            3'd0:    return {4'h0, m_ctrl};
            3'd1:    return m_cnt;
            3'd7:    return ID_WORD;
            default: return {4'h0, m_scr[s]};
        endcase
    endfunction

    task automatic model_apply(input logic [15:0] w);
        logic [2:0] s;
        s = m_ctrl[2:0];
        if (w[3:2] == 2'b00) begin
            if (w[1]) begin
                if (!w[0] || s == 3'd0) m_ctrl = w[15:4];
                else if (s != 3'd1 && s != 3'd7) m_scr[s] = w[15:4];
            end else begin
                if (w[0]) begin
                    m_tx = model_view(s);
                    m_cnt = m_cnt + 16'd1;
                end else begin
                    m_tx = {4'h0, m_ctrl};
                end
            end
        end
    endtask

    // Driver: full 16-bit transfer, mode 0, MSB first
    task automatic xfer(input logic [15:0] w, input string tag);
        logic [15:0] got;
        exp_q.push_back(m_tx);
        tag_q.push_back(tag);
        spi_cs_n = 1'b0;
        #20;
        for (int i = 15; i >= 0; i--) begin
            spi_mosi = w[i];
            #10;
            got[i] = spi_miso;
            #10 spi_sclk = 1'b1;
            #20 spi_sclk = 1'b0;
        end
        #20 spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        #200;
        model_apply(w);
        act_q.push_back(got);
        -> xfer_ev;
        #10;
    endtask

    // Truncated frame: only the first n bits
    task automatic xfer_short(input logic [15:0] w, input int n);
        spi_cs_n = 1'b0;
        #20;
        for (int i = 15; i > 15 - n; i--) begin
            spi_mosi = w[i];
            #20 spi_sclk = 1'b1;
            #20 spi_sclk = 1'b0;
        end
        #20 spi_cs_n = 1'b1;
        #200;
    endtask

    // Monitor: compare each response word against the model
    always @(xfer_ev) begin
        while (act_q.size() > 0) begin
            logic [15:0] a;
            logic [15:0] e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(a == e, t, a, e);
        end
    end

    task automatic check_led(input string tag);
        check(led_out == m_ctrl[6:3], tag, {12'h0, led_out}, {12'h0, m_ctrl[6:3]});
    endtask

    initial begin
        for (int i = 0; i < 8; i++) m_scr[i] = '0;
        #50 rst_n = 1'b1;
        #50;
        check(led_out == 4'h0, "R1 led reset", {12'h0, led_out}, 16'h0);
        check(spi_miso == 1'b0, "R1 miso idle", {15'h0, spi_miso}, 16'h0);

        xfer(16'h0000, "R1 first response");                 // read port 0
        xfer({12'h052, 4'b0010}, "R3 read result delayed");  // ctrl: led A, sel 2
        check_led("R6 led from ctrl");
        xfer(16'h0000, "R3 write leaves response");          // read port 0
        xfer({12'hABC, 4'b0011}, "R5 ctrl readback");        // scratch 2 <- ABC
        xfer(16'h0001, "R3 write leaves response");          // read port 1 (scratch 2)
        xfer({12'h051, 4'b0010}, "R2 R7 scratch bit order"); // sel 1 counter
        xfer(16'h0001, "R5 ctrl write");                     // read counter
        xfer(16'h0001, "R9 counter before read");
        xfer(16'h0000, "R9 counter increments");             // port 0 read
        xfer({12'hFFF, 4'b0011}, "R5 port0 readback");       // write to counter: ignored
        xfer(16'h0001, "R8 write response hold");
        xfer({12'h000, 4'b0110}, "R8 counter not written");  // reserved bit: ignored
        check_led("R4 reserved cmd ignored");
        xfer({12'h057, 4'b0010}, "R4 reserved keeps response");  // sel 7
        xfer({12'h123, 4'b0011}, "R3 hold");                 // write to id: ignored
        xfer(16'h0001, "R3 hold");                           // read id
        xfer({12'h028, 4'b0010}, "R7 id constant");          // sel 0
        xfer({12'h063, 4'b0011}, "R3 hold");                 // alias write ctrl
        check_led("R7 alias write moves led");
        xfer(16'h0000, "R3 hold");                           // read port 0
        xfer({12'h456, 4'b0011}, "R7 alias readback");       // scratch 3
        xfer(16'h0001, "R3 hold");
        xfer({12'h062, 4'b0010}, "R7 scratch3");             // sel 2
        xfer(16'h0001, "R3 hold");
        xfer_short({12'h000, 4'b0010}, 10);                  // truncated write of ctrl
        check_led("R10 short frame no write");
        xfer_short(16'h0001, 12);                            // truncated read
        xfer(16'h0000, "R10 short frame no read scratch2");
        xfer(16'h0001, "R6 ctrl intact");
        xfer(16'h0000, "R9 counter final");
        #100;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got 0x%04h expected 0x%04h", 16'h0, 16'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule